// File: doc/BRIEF.md
# Two-Stage Half-Step Clock Divider

This block derives a slow shift clock from a fast core clock for a serializer further down the path. Two fractional divider stages sit in series. Each stage takes a 5-bit code and divides by any ratio from 1 to 16 in half steps. The overall division is the product of the two stage ratios. A half ratio N+0.5 is made by alternating periods of N+1 and N input events, so the average period is exact.

Two outputs are provided. `rise_tick` is a single-core-cycle strobe for each rising edge of the divided clock, and a serializer would shift one bit on it. `div_clk` is a clock level for observation or for a pin. The divider is started and stopped with `run_en`. Codes are captured only while `run_en` is low, so reprogramming while running has no effect.

Top module: `hsdiv_cascade`

## Requirements
- R1: A stage with code c divides by (c+2)/2. Code 00h gives 1, 02h gives 2, 12h gives 10, 17h gives 12.5 and 1Eh gives 16. With both codes 00h, `rise_tick` is high in every cycle while running.
- R2: A stage with code c emits its m-th output on its input event number ceil(m·(c+2)/2). An odd code therefore alternates periods of N+1 and N input events.
- R3: Number the core edges from 1, starting at the first edge that samples `run_en` high. Let L0 = code0+2 and L1 = code1+2. The j-th `rise_tick` is high in the cycle after edge ceil(ceil(j·L1/2)·L0/2).
- R4: Two full periods take 50 cycles for codes 17h/02h, 40 for 12h/02h, 20 for 12h/00h and 25 for 17h/00h.
- R5: `rise_tick` is high only in the cycles named by R3. The number of strobes seen over a run equals the number R3 predicts.
- R6: `div_clk` rises with each `rise_tick` and stays high for H = max(1, floor(L0·L1/8)) cycles, then falls. A strobe that arrives while it is high keeps it high and restarts the count.
- R7: When `run_en` is sampled low, both outputs are low after that edge and the stage counters are cleared. A later start follows R3 again from edge 1.
- R8: Codes are sampled only at edges where `run_en` is low. Changing the code inputs while running does not alter the strobe timing.
- R9: Any code above 1Eh is treated as 1Eh.
- R10: During and directly after reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run control; codes are captured while low |
| div0_code | input | 5 | First stage code, ratio (code+2)/2 |
| div1_code | input | 5 | Second stage code, ratio (code+2)/2 |
| div_clk | output | 1 | Divided clock level |
| rise_tick | output | 1 | One-cycle strobe per divided rising edge |

## Verification
The embedded properties take for granted that the captured codes never move while `run_en` is high. Under that assumption, the stage accumulators stay below their limits and the gap between strobes stays within a bound computed from the captured codes. The stimulus keeps to this: every configuration is applied while the divider is idle, with at least one idle edge before start. The single run that alters the code pins mid-flight does so to show that the captured codes are kept.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;

   // Number of divider stages in the cascade (fixed by the port list).
   localparam int NUM_STAGES = 2;

   // Clamp a raw code to the largest legal value.
   function automatic logic [7:0] clamp_code(input logic [7:0] raw, input logic [7:0] cmax);
      return (raw > cmax) ? cmax : raw;
   endfunction

endpackage

// File: rtl/hsdiv_stage.sv
// One fractional stage: counts input events in half units, so any
// ratio (code+2)/2 comes out with no separate odd/even handling.
module hsdiv_stage #(
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_tick,
   input  logic [CODE_W-1:0] code,
   output logic              out_tick
);
   localparam int ACC_W = CODE_W + 2;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] lim;
   logic [ACC_W-1:0] sum;

   assign lim      = ACC_W'(code) + ACC_W'(2);
   assign sum      = acc_q + ACC_W'(2);
   assign out_tick = in_tick && (sum >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (in_tick) begin
         acc_q <= out_tick ? (sum - lim) : sum;
      end
   end

   // R2: the accumulator never reaches the wrap limit of its stage.
   p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < lim);

endmodule

// File: rtl/hsdiv_level.sv
// Turns the final strobe into a registered strobe and a clock level with
// a computed high time.
module hsdiv_level #(
   parameter int HOLD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [HOLD_W-1:0] hold_len,
   output logic              level,
   output logic              rise
);
   logic [HOLD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
         rise  <= 1'b0;
         cnt_q <= '0;
      end else if (!run) begin
         level <= 1'b0;
         rise  <= 1'b0;
         cnt_q <= '0;
      end else begin
         rise <= tick;
         if (tick) begin
            level <= 1'b1;
            cnt_q <= hold_len - HOLD_W'(1);
         end else if (level) begin
            if (cnt_q == '0) level <= 1'b0;
            else             cnt_q <= cnt_q - HOLD_W'(1);
         end
      end
   end

   // R6: a strobe is always accompanied by a high clock level.
   p_tick_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> level);

   // R7: stopping forces both outputs low at the next edge.
   p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!level && !rise));

endmodule

// File: rtl/hsdiv_cascade.sv
module hsdiv_cascade
   import hsdiv_pkg::*;
#(
   parameter int CODE_W   = 5,
   parameter int CODE_MAX = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic [CODE_W-1:0] div0_code,
   input  logic [CODE_W-1:0] div1_code,
   output logic              div_clk,
   output logic              rise_tick
);
   localparam int LIM_W  = CODE_W + 2;
   localparam int HOLD_W = 2 * LIM_W;
   localparam int GAP_W  = HOLD_W + 1;

   if (CODE_W < 2 || CODE_W > 8) begin : g_bad_w
      $error("hsdiv_cascade: CODE_W must lie in 2..8");
   end
   if (CODE_MAX < 0 || CODE_MAX >= (1 << CODE_W)) begin : g_bad_max
      $error("hsdiv_cascade: CODE_MAX must fit in CODE_W bits");
   end

   logic [NUM_STAGES-1:0][CODE_W-1:0] code_raw;
   logic [NUM_STAGES-1:0][CODE_W-1:0] code_q;
   logic [NUM_STAGES:0]               tick_c;
   logic [LIM_W-1:0]                  lim0, lim1;
   logic [HOLD_W-1:0]                 prod, hold_len;

   assign code_raw[0] = div0_code;
   assign code_raw[1] = div1_code;

   // Codes are captured only while idle (R8), clamped on the way in (R9).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else if (!run_en) begin
         for (int i = 0; i < NUM_STAGES; i++) begin
            code_q[i] <= CODE_W'(clamp_code(8'(code_raw[i]), 8'(CODE_MAX)));
         end
      end
   end

   assign tick_c[0] = run_en;

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      hsdiv_stage #(.CODE_W(CODE_W)) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (!run_en),
         .in_tick  (tick_c[s]),
         .code     (code_q[s]),
         .out_tick (tick_c[s+1])
      );
   end

   assign lim0     = LIM_W'(code_q[0]) + LIM_W'(2);
   assign lim1     = LIM_W'(code_q[1]) + LIM_W'(2);
   assign prod     = HOLD_W'(lim0) * HOLD_W'(lim1);
   assign hold_len = ((prod >> 3) == '0) ? HOLD_W'(1) : (prod >> 3);

   hsdiv_level #(.HOLD_W(HOLD_W)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_en),
      .tick     (tick_c[NUM_STAGES]),
      .hold_len (hold_len),
      .level    (div_clk),
      .rise     (rise_tick)
   );

   // R8: captured codes stay put across consecutive running edges.
   p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && $past(run_en)) |-> $stable(code_q));

   // R3: no divided period exceeds ceil(L0/2)*ceil(L1/2) core cycles.
   logic [GAP_W-1:0] gap_q;
   logic [GAP_W-1:0] gap_max;
   assign gap_max = GAP_W'((lim0 + LIM_W'(1)) >> 1) * GAP_W'((lim1 + LIM_W'(1)) >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             gap_q <= '0;
      else if (!run_en || tick_c[NUM_STAGES]) gap_q <= '0;
      else                                    gap_q <= gap_q + GAP_W'(1);
   end

   p_period_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q < gap_max);

endmodule

// File: tb/hsdiv_cascade_tb.sv
`timescale 1ns/1ps
module hsdiv_cascade_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic [4:0] div0_code = '0;
   logic [4:0] div1_code = '0;
   logic       div_clk, rise_tick;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hsdiv_cascade u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .div0_code(div0_code), .div1_code(div1_code),
      .div_clk(div_clk), .rise_tick(rise_tick)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Edge index of the j-th strobe (R3): ceil(ceil(j*L1/2)*L0/2).
   function automatic int tj(input int j, input int l0, input int l1);
      int s;
      s = (j * l1 + 1) / 2;
      return (s * l0 + 1) / 2;
   endfunction

   // Runs one configuration; returns edge distance from first to last strobe.
   task automatic run_case(input string tag, input int c0, input int c1,
                           input int rises, input bit poke, output int span);
      int e0, e1, l0, l1, hl, j, nxt, last_t, limit, first, lastobs, seen;
      bit exp_t, exp_l;
      e0 = (c0 > 30) ? 30 : c0;
      e1 = (c1 > 30) ? 30 : c1;
      l0 = e0 + 2;
      l1 = e1 + 2;
      hl = (l0 * l1) / 8;
      if (hl < 1) hl = 1;
      j = 1; nxt = tj(1, l0, l1); last_t = 0;
      limit = tj(rises, l0, l1) + hl + 2;
      first = -1; lastobs = -1; seen = 0;
      @(negedge clk);
      run_en = 1'b0; div0_code = 5'(c0); div1_code = 5'(c1);
      @(posedge clk); @(negedge clk);
      chk({tag, " R7 idle div_clk"}, int'(div_clk), 0);
      chk({tag, " R7 idle rise_tick"}, int'(rise_tick), 0);
      run_en = 1'b1;
      for (int n = 1; n <= limit; n++) begin
         @(posedge clk); @(negedge clk);
         exp_t = (n == nxt);
         if (exp_t) begin
            last_t = n; j++; nxt = tj(j, l0, l1);
         end
         exp_l = (last_t > 0) && (n - last_t < hl);
         chk({tag, " R3 rise_tick"}, int'(rise_tick), int'(exp_t));
         chk({tag, " R6 div_clk"}, int'(div_clk), int'(exp_l));
         if (rise_tick) begin
            seen++;
            if (first < 0) first = n;
            if (seen <= rises) lastobs = n;
         end
         if (poke && n == 1) begin
            div0_code = ~5'(c0);
            div1_code = ~5'(c1);
         end
      end
      chk({tag, " R5 strobe count"}, seen, j - 1);
      run_en = 1'b0;
      @(posedge clk); @(negedge clk);
      chk({tag, " R7 stop div_clk"}, int'(div_clk), 0);
      chk({tag, " R7 stop rise_tick"}, int'(rise_tick), 0);
      span = lastobs - first;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int span, span30;
      repeat (3) @(negedge clk);
      chk("R10 reset div_clk", int'(div_clk), 0);
      chk("R10 reset rise_tick", int'(rise_tick), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 post-reset div_clk", int'(div_clk), 0);
      chk("R10 post-reset rise_tick", int'(rise_tick), 0);

      // R1: both stages transparent, strobe on every cycle.
      run_case("R1", 0, 0, 6, 1'b0, span);
      chk("R1 span 00h/00h", span, 5);

      // R4: ratio examples, two full periods each.
      run_case("R4", 23, 2, 3, 1'b0, span);  chk("R4 17h/02h", span, 50);
      run_case("R4", 18, 2, 3, 1'b0, span);  chk("R4 12h/02h", span, 40);
      run_case("R4", 18, 0, 3, 1'b0, span);  chk("R4 12h/00h", span, 20);
      run_case("R4", 23, 0, 3, 1'b0, span);  chk("R4 17h/00h", span, 25);
      run_case("R1", 30, 0, 3, 1'b0, span);  chk("R1 1Eh/00h", span, 32);

      // R2: first stage swept over every code against several second stages.
      for (int a = 0; a < 32; a++) begin
         run_case("R2", a, 0, 3, 1'b0, span);
         run_case("R2", a, 1, 3, 1'b0, span);
         run_case("R2", a, 2, 3, 1'b0, span);
         run_case("R2", a, 30, 2, 1'b0, span);
      end
      // R3: second stage swept against fixed first stages.
      for (int b = 0; b < 32; b++) begin
         run_case("R3", 0, b, 3, 1'b0, span);
         run_case("R3", 1, b, 3, 1'b0, span);
         run_case("R3", 23, b, 2, 1'b0, span);
      end

      // R9: code 1Fh behaves exactly as 1Eh.
      run_case("R9", 30, 3, 3, 1'b0, span30);
      run_case("R9", 31, 3, 3, 1'b0, span);
      chk("R9 clamp span", span, span30);

      // R8: code pins moved while running are not taken.
      run_case("R8", 5, 3, 4, 1'b1, span);
      run_case("R8", 0, 0, 3, 1'b1, span);
      chk("R8 span after poke", span, 2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule